// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block is the issue controller of a single-issue pipeline with three functional units. The decoder presents one instruction at a time. Each instruction carries an operation class that selects a unit, a destination register and two source registers. Each cycle the controller decides whether the presented instruction may leave for its unit or must wait. Instructions leave strictly in the order they are presented. A waiting instruction holds back everything behind it.

The controller keeps two tables. The first records which registers still await a result. The second holds a per-unit countdown that is loaded with that unit's latency when an instruction issues. When a countdown finishes, the unit reports completion: a writeback strobe carrying the destination tag. The matching register is then released. Units of different latency can therefore finish in a different order from the one in which they were issued.

A finishing unit releases its resources in the same cycle that it reports completion. The instruction presented in that cycle can therefore use the freed unit or register straight away.

Top module: `issue_scoreboard`

## Requirements
- R1: The instruction is taken in a cycle where `dec_valid` and `dec_ready` are both high. At most one instruction is taken per cycle. While `dec_ready` is low the presented instruction waits, and nothing behind it can go.
- R2: Class code 0 selects unit 0 (latency `LAT_U0`, default 1). Class code 1 selects unit 1 (latency `LAT_U1`, default 2). Class code 2 selects unit 2 (latency `LAT_U2`, default 1).
- R3: `dec_ready` is low while the selected unit still holds an earlier instruction that does not finish in the current cycle.
- R4: `dec_ready` is low while either source register awaits the result of an earlier instruction that does not finish in the current cycle.
- R5: `dec_ready` is low while the destination register awaits the result of an earlier instruction that does not finish in the current cycle.
- R6: Register 0 never awaits a result. Naming it as a source or as a destination never causes a wait.
- R7: An instruction taken on unit u in cycle t raises `wb_valid[u]` for exactly one cycle, in cycle t+latency. In that cycle the u-th slice of `wb_tag` shows its destination register.
- R8: A completion in cycle c frees both its unit and its destination register for the instruction presented in cycle c.
- R9: Completions may arrive in a different order from the issue order. For example, a unit-0 instruction taken one cycle after a unit-1 instruction finishes in the same cycle as the unit-1 instruction.
- R10: After reset, `dec_ready` is high for any instruction and `wb_valid` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoder presents an instruction |
| dec_ready | output | 1 | Presented instruction may issue this cycle |
| dec_cls | input | 2 | Operation class, selects the unit |
| dec_dst | input | REG_W | Destination register |
| dec_src_a | input | REG_W | First source register |
| dec_src_b | input | REG_W | Second source register |
| wb_valid | output | 3 | Per-unit completion strobe |
| wb_tag | output | 3*REG_W | Per-unit destination tag, unit u in slice u |

## Verification
A register flag left set, or a countdown left non-zero, shows up at the ports as `dec_ready` low for an instruction that should pass. It appears in the first cycle that such an instruction is presented. A flag or countdown cleared too early shows up as `dec_ready` high during a real hazard. A completion strobe one cycle early or late, or with the wrong tag, differs from the reference in that same cycle. A missing release then turns into a permanent stall within a few cycles. Because the reference model is compared on every clock, each of these faults is reported in the cycle it first becomes visible.

// File: rtl/isb_pkg.sv
package isb_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    CLS_U0 = 2'd0,
    CLS_U1 = 2'd1,
    CLS_U2 = 2'd2
  } op_cls_e;

  // countdown reaches its last cycle: completion is reported now
  function automatic logic cnt_retires(input cnt_t c);
    return c == cnt_t'(1);
  endfunction

  // unit can accept a new instruction this cycle (idle or finishing)
  function automatic logic cnt_frees(input cnt_t c);
    return c <= cnt_t'(1);
  endfunction

  function automatic cnt_t cnt_tick(input cnt_t c);
    return (c == '0) ? '0 : c - cnt_t'(1);
  endfunction
endpackage

// File: rtl/unit_timer.sv
module unit_timer
  import isb_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LAT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_dst,
  output logic             free_o,
  output logic             done_o,
  output logic [REG_W-1:0] done_dst
);
  cnt_t             cnt_q;
  logic [REG_W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dst_q <= '0;
    end else if (load) begin
      cnt_q <= cnt_t'(LAT);
      dst_q <= load_dst;
    end else begin
      cnt_q <= cnt_tick(cnt_q);
    end
  end

  assign free_o   = cnt_frees(cnt_q);
  assign done_o   = cnt_retires(cnt_q);
  assign done_dst = dst_q;

  // a unit is only loaded when it is idle or in its final cycle
  assert_load_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q <= cnt_t'(1)));
  // a load always produces a countdown of the unit latency
  assert_load_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == cnt_t'(LAT)));
endmodule

// File: rtl/pend_table.sv
module pend_table #(
  parameter int NREGS = 32,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic [NREGS-1:0] clr_mask,
  output logic [NREGS-1:0] pend_q
);
  logic [NREGS-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  assert_reg0_never_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0]);
  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_idx)]);
endmodule

// File: rtl/hazard_check.sv
module hazard_check
  import isb_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int REG_W  = 5,
  parameter int NUNITS = 3
) (
  input  logic [NREGS-1:0]  pend_eff,
  input  logic [NUNITS-1:0] unit_free,
  input  logic [1:0]        cls,
  input  logic [REG_W-1:0]  dst,
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  output logic              fu_hit,
  output logic              raw_hit,
  output logic              waw_hit,
  output logic              ok
);
  logic unit_ok;

  always_comb begin
    unit_ok = 1'b0;
    for (int u = 0; u < NUNITS; u++)
      if (cls == 2'(u)) unit_ok = unit_free[u];
  end

  assign fu_hit  = !unit_ok;
  assign raw_hit = pend_eff[src_a] | pend_eff[src_b];
  assign waw_hit = pend_eff[dst];
  assign ok      = !(fu_hit | raw_hit | waw_hit);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import isb_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int LAT_U0 = 1,
  parameter int LAT_U1 = 2,
  parameter int LAT_U2 = 1,
  localparam int REG_W  = $clog2(NREGS),
  localparam int NUNITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_valid,
  output logic                    dec_ready,
  input  logic [1:0]              dec_cls,
  input  logic [REG_W-1:0]        dec_dst,
  input  logic [REG_W-1:0]        dec_src_a,
  input  logic [REG_W-1:0]        dec_src_b,
  output logic [NUNITS-1:0]       wb_valid,
  output logic [NUNITS*REG_W-1:0] wb_tag
);
  function automatic int lat_of(input int u);
    case (u)
      0:       return LAT_U0;
      1:       return LAT_U1;
      default: return LAT_U2;
    endcase
  endfunction

  // named internal events
  logic                    issue_fire;
  logic [NUNITS-1:0]       unit_load;
  logic [NUNITS-1:0]       unit_free;
  logic [NUNITS-1:0]       unit_done;
  logic [REG_W-1:0]        unit_dst [NUNITS];
  logic [NREGS-1:0]        clr_mask;
  logic [NREGS-1:0]        pend_q;
  logic [NREGS-1:0]        pend_eff;
  logic                    fu_hit, raw_hit, waw_hit, hz_ok;

  assign issue_fire = dec_valid && dec_ready;

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    assign unit_load[u] = issue_fire && (dec_cls == 2'(u));
    unit_timer #(.REG_W(REG_W), .LAT(lat_of(u))) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (unit_load[u]),
      .load_dst (dec_dst),
      .free_o   (unit_free[u]),
      .done_o   (unit_done[u]),
      .done_dst (unit_dst[u])
    );
    assign wb_valid[u]                  = unit_done[u];
    assign wb_tag[u*REG_W +: REG_W]     = unit_dst[u];

    // a completing unit always releases a register that was awaiting it
    assert_wb_tag_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_done[u] && unit_dst[u] != '0) |-> pend_q[unit_dst[u]]);
  end

  always_comb begin
    clr_mask = '0;
    for (int u = 0; u < NUNITS; u++)
      if (unit_done[u]) clr_mask[unit_dst[u]] = 1'b1;
  end

  // completion release is seen by the hazard check in the same cycle
  assign pend_eff = pend_q & ~clr_mask;

  pend_table #(.NREGS(NREGS), .REG_W(REG_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (issue_fire && dec_dst != '0),
    .set_idx  (dec_dst),
    .clr_mask (clr_mask),
    .pend_q   (pend_q)
  );

  hazard_check #(.NREGS(NREGS), .REG_W(REG_W), .NUNITS(NUNITS)) u_hz (
    .pend_eff  (pend_eff),
    .unit_free (unit_free),
    .cls       (dec_cls),
    .dst       (dec_dst),
    .src_a     (dec_src_a),
    .src_b     (dec_src_b),
    .fu_hit    (fu_hit),
    .raw_hit   (raw_hit),
    .waw_hit   (waw_hit),
    .ok        (hz_ok)
  );

  assign dec_ready = hz_ok;

  assert_single_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_load));
  assert_no_raw_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> !(pend_q[dec_src_a] && !clr_mask[dec_src_a]));
  assert_no_waw_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> !(pend_q[dec_dst] && !clr_mask[dec_dst]));
  assert_stall_reason_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |-> (fu_hit || raw_hit || waw_hit));
endmodule

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;
  localparam int NREGS = 32;
  localparam int REG_W = 5;
  localparam int LATS [3] = '{1, 2, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic dec_ready;
  logic [1:0] dec_cls = '0;
  logic [REG_W-1:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
  logic [2:0] wb_valid;
  logic [3*REG_W-1:0] wb_tag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 0;

  // reference model state
  int rem [3];
  int mdst [3];
  bit pend [NREGS];

  always #2 clk = ~clk;

  issue_scoreboard u_issue_scoreboard (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_cls(dec_cls), .dec_dst(dec_dst), .dec_src_a(dec_src_a),
    .dec_src_b(dec_src_b), .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model
  task automatic step(input bit v, input int cls, input int d, input int a,
                      input int b, input string req, output bit fired);
    bit comp [3];
    bit eff [NREGS];
    bit exp_rdy;
    @(negedge clk);
    dec_valid = v; dec_cls = 2'(cls); dec_dst = REG_W'(d);
    dec_src_a = REG_W'(a); dec_src_b = REG_W'(b);
    #1;
    for (int r = 0; r < NREGS; r++) eff[r] = pend[r];
    for (int u = 0; u < 3; u++) begin
      comp[u] = (rem[u] == 1);
      if (comp[u]) eff[mdst[u]] = 0;
    end
    exp_rdy = (rem[cls] <= 1) && !eff[a] && !eff[b] && !eff[d];
    check(dec_ready == exp_rdy, req, "dec_ready", int'(dec_ready), int'(exp_rdy));
    for (int u = 0; u < 3; u++) begin
      check(wb_valid[u] == comp[u], "R7", "wb_valid", int'(wb_valid[u]), int'(comp[u]));
      if (comp[u])
        check(int'(wb_tag[u*REG_W +: REG_W]) == mdst[u], "R7", "wb_tag",
              int'(wb_tag[u*REG_W +: REG_W]), mdst[u]);
    end
    fired = v && exp_rdy;
    for (int u = 0; u < 3; u++) begin
      if (comp[u]) pend[mdst[u]] = 0;
      if (rem[u] > 0) rem[u]--;
    end
    if (fired) begin
      rem[cls] = LATS[cls];
      mdst[cls] = d;
      if (d != 0) pend[d] = 1;
    end
  endtask

  // present one instruction until taken; report how many cycles it waited
  task automatic send(input int cls, input int d, input int a, input int b,
                      input string req, output int waited);
    bit f;
    waited = 0;
    step(1, cls, d, a, b, req, f);
    while (!f && waited < 50) begin
      waited++;
      step(1, cls, d, a, b, req, f);
    end
  endtask

  task automatic idle(input int n);
    bit f;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "R1", f);
  endtask

  initial begin
    while (!done_flag) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(0, "R1", "watchdog", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int w;
    int w2;
    for (int u = 0; u < 3; u++) begin rem[u] = 0; mdst[u] = 0; end
    for (int r = 0; r < NREGS; r++) pend[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: empty after reset
    check(dec_ready == 1'b1, "R10", "ready after reset", int'(dec_ready), 1);
    check(wb_valid == 3'b000, "R10", "wb after reset", int'(wb_valid), 0);

    // R2/R7: each class lands on its unit with its latency
    send(0, 1, 0, 0, "R2", w); idle(3);
    send(1, 2, 0, 0, "R2", w); idle(3);
    send(2, 3, 0, 0, "R2", w); idle(3);

    // R3: back-to-back on the two-cycle unit waits one cycle
    send(1, 4, 0, 0, "R3", w);
    send(1, 5, 0, 0, "R3", w);
    check(w == 1, "R3", "structural wait", w, 1);
    idle(3);

    // R4/R8: consumer of a two-cycle result waits one cycle, then takes the freed register
    send(1, 6, 0, 0, "R4", w);
    send(0, 7, 6, 0, "R4", w);
    check(w == 1, "R4", "RAW wait", w, 1);
    idle(3);
    send(0, 8, 0, 0, "R8", w);
    send(2, 9, 0, 8, "R8", w);
    check(w == 0, "R8", "same-cycle release", w, 0);
    idle(3);

    // R5: rewriting a pending register waits
    send(1, 10, 0, 0, "R5", w);
    send(2, 10, 0, 0, "R5", w);
    check(w == 1, "R5", "WAW wait", w, 1);
    idle(3);

    // R6: register 0 causes no wait
    send(1, 0, 0, 0, "R6", w);
    send(0, 0, 0, 0, "R6", w);
    check(w == 0, "R6", "reg0 dst/src", w, 0);
    idle(3);

    // R9: unit 1 then unit 0 finish together (out of order relative to a later unit-2)
    send(1, 11, 0, 0, "R9", w);
    send(0, 12, 0, 0, "R9", w2);
    check(w2 == 0, "R9", "independent issue", w2, 0);
    idle(3);

    // R1: stalled head blocks the next; random stream compared every cycle
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      send($urandom_range(0, 2), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), "R1", w);
      check(w < 50, "R1", "instruction eventually issues", w, 0);
    end
    idle(4);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule